// File: doc/BRIEF.md
# TDM dual-highway time-slot gate

This block connects a framer's internal per-slot byte streams to a serial time-division bus that has two parallel highways, A and B, in each direction. A frame is 32 slots of 8 bits, one bit per clock. A frame-sync pulse aligns the block's internal bit and slot position.

Each outbound slot goes onto highway A, onto highway B, or onto neither. A per-highway drive-enable output tells the pad logic when to drive; when it is low, the pad is in high impedance. Each inbound slot is shifted in from the highway chosen for it. A slot that is disabled has its sampled byte replaced by a programmable idle byte.

A byte-wide write/read port holds the per-slot control bits and the idle byte. The control values for a slot are captured at the slot's first bit. A register write made partway through a slot therefore only affects later slots.

Top module: `tdm_slot_gate`

## Requirements
- R1: After synchronous reset:
  - The outbound enable registers read 0x00.
  - The inbound enable registers read 0xFF.
  - Both select groups read 0x00.
  - The idle byte reads 0xFF.
  - Both drive enables and `rx_valid` are low.
- R2: The control map has byte registers at the following addresses. Reads are combinational. Any other address reads 0x00, and writes to it change nothing.

  | Address | Contents |
  |---|---|
  | 0–3 | Outbound enable |
  | 4–7 | Inbound enable |
  | 8–11 | Outbound highway select |
  | 12–15 | Inbound highway select |
  | 16 | Idle byte |

  Within each group of four, bit n at group offset k controls slot 8k+n.
- R3: Bit positions are numbered slot×8+bit and wrap after 256 clocks.
  - A cycle with `fsync` high is position slot 0, bit 0, whatever the free-running count was.
  - Otherwise each clock advances the position by one.
- R4: In each outbound slot, `tx_byte` is taken at bit 0 and sent MSB first.
  - For position (s,b), the outputs update on that clock edge.
  - If slot s is enabled with select 0, highway A drives bit 7−b with its drive enable high.
  - If slot s is enabled with select 1, highway B does the same.
  - A disabled slot has both drive enables low.
  - Data outputs are 0 whenever their drive enable is low.
- R5: The two outbound drive enables are never high in the same cycle.
- R6: Inbound bits are sampled MSB first from highway A (select 0) or B (select 1). On the clock of bit 7 of slot s:
  - `rx_valid` rises for exactly one cycle.
  - `rx_slot` = s.
  - `rx_byte` holds the assembled byte.
- R7: For an inbound slot whose enable bit is 0, `rx_byte` carries the idle byte instead of the sampled data.
- R8: Enables, selects and the idle byte are captured at bit 0 of each slot. A write made during a slot does not change that slot's outputs; it applies from the next slot on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Marks slot 0 bit 0 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data |
| tx_byte | input | 8 | Outbound byte of the current slot |
| hwa_tx_d | output | 1 | Highway A outbound data |
| hwa_tx_oe | output | 1 | Highway A drive enable |
| hwb_tx_d | output | 1 | Highway B outbound data |
| hwb_tx_oe | output | 1 | Highway B drive enable |
| hwa_rx_d | input | 1 | Highway A inbound data |
| hwb_rx_d | input | 1 | Highway B inbound data |
| rx_byte | output | 8 | Assembled or idle inbound byte |
| rx_slot | output | 5 | Slot number of `rx_byte` |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |

## Verification
The bench runs whole frames under a sequence of per-slot settings. These include slots at register edges (0, 7, 8, 15, 23, 24, 31), where a wrong bit-to-slot mapping would route the wrong slot or the wrong highway.

A slot is enabled by a write landing at bit 3 of that same slot. A design that does not capture the control bits at the slot boundary would start driving mid-byte.

The free-running count is deliberately left out of step before a frame sync. A counter that ignored the sync would shift every slot.

Disabled inbound slots must show the programmed idle byte rather than the line data. A write to an unmapped address must leave every register readback unchanged.

// File: rtl/tdm_gate_pkg.sv
package tdm_gate_pkg;
  typedef enum logic [1:0] {
    GRP_TX_EN  = 2'd0,
    GRP_RX_EN  = 2'd1,
    GRP_TX_SEL = 2'd2,
    GRP_RX_SEL = 2'd3
  } ctl_grp_e;
endpackage

// File: rtl/tdm_ctrl_regs.sv
module tdm_ctrl_regs import tdm_gate_pkg::*; #(
  parameter int SLOTS    = 32,
  parameter int W        = 8,
  parameter int AW       = 5,
  parameter int IDLE_RST = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [SLOTS-1:0] tx_en,
  output logic [SLOTS-1:0] rx_en,
  output logic [SLOTS-1:0] tx_sel,
  output logic [SLOTS-1:0] rx_sel,
  output logic [W-1:0]     idle
);
  localparam int NREG = SLOTS / W;
  localparam int SW   = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [AW-1:0] NCTL_A = AW'(4 * NREG);
  localparam logic [AW-1:0] NREG_A = AW'(NREG);

  logic [SLOTS-1:0] grp_q [4];
  logic [W-1:0]     idle_q;
  logic [1:0]       grp_idx;
  logic [SW-1:0]    sub_idx;

  assign grp_idx = 2'(addr / NREG_A);
  assign sub_idx = SW'(addr % NREG_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < 4; g++)
        grp_q[g] <= (g == int'(GRP_RX_EN)) ? '1 : '0;
      idle_q <= W'(IDLE_RST);
    end else if (we) begin
      if (addr < NCTL_A)
        grp_q[grp_idx][sub_idx*W +: W] <= wdata;
      else if (addr == NCTL_A)
        idle_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < NCTL_A)
      rdata = grp_q[grp_idx][sub_idx*W +: W];
    else if (addr == NCTL_A)
      rdata = idle_q;
  end

  assign tx_en  = grp_q[GRP_TX_EN];
  assign rx_en  = grp_q[GRP_RX_EN];
  assign tx_sel = grp_q[GRP_TX_SEL];
  assign rx_sel = grp_q[GRP_RX_SEL];
  assign idle   = idle_q;
endmodule

// File: rtl/tdm_frame_cnt.sv
module tdm_frame_cnt #(
  parameter int SLOTS = 32,
  parameter int W     = 8,
  localparam int BW   = $clog2(W),
  localparam int SLW  = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fsync,
  output logic [SLW-1:0] cur_slot,
  output logic [BW-1:0]  cur_bit
);
  localparam int PW = BW + SLW;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] pos;

  // sync overrides the running count in the same cycle
  assign pos = fsync ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= pos + PW'(1);
  end

  assign cur_bit  = pos[BW-1:0];
  assign cur_slot = pos[PW-1:BW];
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
  parameter int SLOTS = 32,
  parameter int W     = 8,
  localparam int BW   = $clog2(W),
  localparam int SLW  = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLW-1:0]   cur_slot,
  input  logic [BW-1:0]    cur_bit,
  input  logic [W-1:0]     tx_byte,
  input  logic [SLOTS-1:0] en_map,
  input  logic [SLOTS-1:0] sel_map,
  output logic             a_d,
  output logic             a_oe,
  output logic             b_d,
  output logic             b_oe
);
  logic [W-1:0] sh_q;
  logic         en_q, sel_q;
  logic         first, en_now, sel_now, bit_now;

  assign first   = (cur_bit == '0);
  assign en_now  = first ? en_map[cur_slot]  : en_q;
  assign sel_now = first ? sel_map[cur_slot] : sel_q;
  assign bit_now = first ? tx_byte[W-1]      : sh_q[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      a_d   <= 1'b0;
      a_oe  <= 1'b0;
      b_d   <= 1'b0;
      b_oe  <= 1'b0;
    end else begin
      sh_q  <= first ? (tx_byte << 1) : (sh_q << 1);
      en_q  <= en_now;
      sel_q <= sel_now;
      a_oe  <= en_now & ~sel_now;
      b_oe  <= en_now &  sel_now;
      a_d   <= en_now & ~sel_now & bit_now;
      b_d   <= en_now &  sel_now & bit_now;
    end
  end
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
  parameter int SLOTS = 32,
  parameter int W     = 8,
  localparam int BW   = $clog2(W),
  localparam int SLW  = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLW-1:0]   cur_slot,
  input  logic [BW-1:0]    cur_bit,
  input  logic             a_d,
  input  logic             b_d,
  input  logic [SLOTS-1:0] en_map,
  input  logic [SLOTS-1:0] sel_map,
  input  logic [W-1:0]     idle,
  output logic [W-1:0]     rx_byte,
  output logic [SLW-1:0]   rx_slot,
  output logic             rx_valid
);
  logic [W-1:0] acc_q, idle_q, idle_now, full;
  logic         en_q, sel_q;
  logic         first, last, en_now, sel_now, smp;

  assign first    = (cur_bit == '0);
  assign last     = (cur_bit == BW'(W - 1));
  assign en_now   = first ? en_map[cur_slot]  : en_q;
  assign sel_now  = first ? sel_map[cur_slot] : sel_q;
  assign idle_now = first ? idle              : idle_q;
  assign smp      = sel_now ? b_d : a_d;
  assign full     = {acc_q[W-2:0], smp};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      idle_q   <= '0;
      en_q     <= 1'b0;
      sel_q    <= 1'b0;
      rx_byte  <= '0;
      rx_slot  <= '0;
      rx_valid <= 1'b0;
    end else begin
      acc_q    <= full;
      idle_q   <= idle_now;
      en_q     <= en_now;
      sel_q    <= sel_now;
      rx_valid <= last;
      if (last) begin
        rx_byte <= en_now ? full : idle_now;
        rx_slot <= cur_slot;
      end
    end
  end
endmodule

// File: rtl/tdm_slot_gate.sv
module tdm_slot_gate #(
  parameter int SLOTS    = 32,
  parameter int W        = 8,
  parameter int IDLE_RST = 255,
  localparam int AW      = $clog2(4 * (SLOTS / W) + 1),
  localparam int BW      = $clog2(W),
  localparam int SLW     = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fsync,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [W-1:0]   reg_wdata,
  output logic [W-1:0]   reg_rdata,
  input  logic [W-1:0]   tx_byte,
  output logic           hwa_tx_d,
  output logic           hwa_tx_oe,
  output logic           hwb_tx_d,
  output logic           hwb_tx_oe,
  input  logic           hwa_rx_d,
  input  logic           hwb_rx_d,
  output logic [W-1:0]   rx_byte,
  output logic [SLW-1:0] rx_slot,
  output logic           rx_valid
);
  logic [SLOTS-1:0] tx_en_map, rx_en_map, tx_sel_map, rx_sel_map;
  logic [W-1:0]     idle_code;
  logic [SLW-1:0]   frm_slot;
  logic [BW-1:0]    frm_bit;

  tdm_ctrl_regs #(.SLOTS(SLOTS), .W(W), .AW(AW), .IDLE_RST(IDLE_RST)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .tx_en(tx_en_map), .rx_en(rx_en_map),
    .tx_sel(tx_sel_map), .rx_sel(rx_sel_map), .idle(idle_code)
  );

  tdm_frame_cnt #(.SLOTS(SLOTS), .W(W)) cnt_i (
    .clk(clk), .rst(rst), .fsync(fsync), .cur_slot(frm_slot), .cur_bit(frm_bit)
  );

  tdm_tx_lane #(.SLOTS(SLOTS), .W(W)) tx_i (
    .clk(clk), .rst(rst), .cur_slot(frm_slot), .cur_bit(frm_bit),
    .tx_byte(tx_byte), .en_map(tx_en_map), .sel_map(tx_sel_map),
    .a_d(hwa_tx_d), .a_oe(hwa_tx_oe), .b_d(hwb_tx_d), .b_oe(hwb_tx_oe)
  );

  tdm_rx_lane #(.SLOTS(SLOTS), .W(W)) rx_i (
    .clk(clk), .rst(rst), .cur_slot(frm_slot), .cur_bit(frm_bit),
    .a_d(hwa_rx_d), .b_d(hwb_rx_d), .en_map(rx_en_map), .sel_map(rx_sel_map),
    .idle(idle_code), .rx_byte(rx_byte), .rx_slot(rx_slot), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/tdm_slot_gate_chk.sv
module tdm_slot_gate_chk #(
  parameter int SLOTS = 32,
  parameter int W     = 8,
  localparam int BW   = $clog2(W),
  localparam int SLW  = $clog2(SLOTS)
) (
  input logic           clk,
  input logic           rst,
  input logic [SLW-1:0] cur_slot,
  input logic [BW-1:0]  cur_bit,
  input logic           a_oe,
  input logic           b_oe,
  input logic           rx_valid,
  input logic [SLW-1:0] rx_slot
);
  // R5
  oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!a_oe && !b_oe && !rx_valid));

  // R8
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cur_bit) != '0) |-> ($stable(a_oe) && $stable(b_oe)));

  // R6
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R6
  rx_slot_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rx_slot == $past(cur_slot) && $past(cur_bit) == BW'(W - 1)));
endmodule

bind tdm_slot_gate tdm_slot_gate_chk #(.SLOTS(SLOTS), .W(W)) chk_i (
  .clk(clk), .rst(rst), .cur_slot(frm_slot), .cur_bit(frm_bit),
  .a_oe(hwa_tx_oe), .b_oe(hwb_tx_oe), .rx_valid(rx_valid), .rx_slot(rx_slot)
);

// File: tb/tdm_slot_gate_tb_top.sv
module tdm_slot_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync = 1'b0;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] tx_byte = '0;
  logic       hwa_tx_d, hwa_tx_oe, hwb_tx_d, hwb_tx_oe;
  logic       hwa_rx_d = 1'b0;
  logic       hwb_rx_d = 1'b0;
  logic [7:0] rx_byte;
  logic [4:0] rx_slot;
  logic       rx_valid;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [31:0] m_ten, m_ren, m_tsel, m_rsel;
  logic [7:0]  m_idle;

  // slot[8:4], outbound enable[3], outbound select[2], inbound enable[1], inbound select[0]
  localparam logic [8:0] VEC [8] = '{
    {5'd0,  4'b1010}, {5'd1,  4'b1111}, {5'd7,  4'b1100}, {5'd8,  4'b0111},
    {5'd15, 4'b1001}, {5'd23, 4'b1110}, {5'd24, 4'b0000}, {5'd31, 4'b1111}
  };

  always #4 clk = ~clk;

  tdm_slot_gate dut_i (
    .clk(clk), .rst(rst), .fsync(fsync), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_byte(tx_byte),
    .hwa_tx_d(hwa_tx_d), .hwa_tx_oe(hwa_tx_oe), .hwb_tx_d(hwb_tx_d),
    .hwb_tx_oe(hwb_tx_oe), .hwa_rx_d(hwa_rx_d), .hwb_rx_d(hwb_rx_d),
    .rx_byte(rx_byte), .rx_slot(rx_slot), .rx_valid(rx_valid)
  );

  function automatic logic [7:0] tx_pat(int s);  return 8'h3C ^ 8'(s * 7);  endfunction
  function automatic logic [7:0] a_pat(int s);   return 8'(s * 11 + 1);     endfunction
  function automatic logic [7:0] b_pat(int s);   return ~8'(s * 5);         endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(int a, logic [7:0] exp, string req);
    @(negedge clk);
    reg_addr = 5'(a);
    #1;
    chk(reg_rdata == exp, req, $sformatf("readback addr %0d", a), reg_rdata, exp);
  endtask

  task automatic push_all();
    for (int k = 0; k < 4; k++) begin
      wr(k,      m_ten[8*k +: 8]);
      wr(4 + k,  m_ren[8*k +: 8]);
      wr(8 + k,  m_tsel[8*k +: 8]);
      wr(12 + k, m_rsel[8*k +: 8]);
    end
    wr(16, m_idle);
  endtask

  // one full frame starting with fsync; optional control write at slot 3 bit 3
  task automatic run_frame(bit mid);
    for (int s = 0; s < 32; s++) begin
      logic [7:0] tb_v, ab, bb, exp_rx;
      logic en, sel;
      int   tx_bad, rx_bad, act_code, exp_code;
      tb_v = tx_pat(s); ab = a_pat(s); bb = b_pat(s);
      en = m_ten[s]; sel = m_tsel[s];
      exp_rx = m_ren[s] ? (m_rsel[s] ? bb : ab) : m_idle;
      tx_bad = 0; rx_bad = 0; act_code = 0; exp_code = 0;
      for (int b = 0; b < 8; b++) begin
        logic bv;
        @(negedge clk);
        fsync    = (s == 0 && b == 0);
        tx_byte  = tb_v;
        hwa_rx_d = ab[7-b];
        hwb_rx_d = bb[7-b];
        if (mid && s == 3 && b == 3) begin
          reg_we = 1'b1; reg_addr = 5'd0; reg_wdata = m_ten[7:0] ^ 8'h08;
        end else begin
          reg_we = 1'b0;
        end
        @(posedge clk); #1;
        bv = tb_v[7-b];
        if (!(hwa_tx_oe == (en & ~sel) && hwb_tx_oe == (en & sel) &&
              hwa_tx_d == (en & ~sel & bv) && hwb_tx_d == (en & sel & bv))) begin
          tx_bad++;
          act_code = {hwa_tx_oe, hwb_tx_oe, hwa_tx_d, hwb_tx_d};
          exp_code = {en & ~sel, en & sel, en & ~sel & bv, en & sel & bv};
        end
        if (b == 7) begin
          if (!(rx_valid && rx_slot == 5'(s) && rx_byte == exp_rx)) rx_bad++;
        end else if (rx_valid) begin
          rx_bad++;
        end
      end
      chk(tx_bad == 0, (mid && s == 3) ? "R8" : "R4,R5",
          $sformatf("outbound slot %0d oeA,oeB,dA,dB", s), act_code, exp_code);
      chk(rx_bad == 0, m_ren[s] ? "R6" : "R7",
          $sformatf("inbound slot %0d valid=%0d slot=%0d", s, rx_valid, rx_slot),
          rx_byte, exp_rx);
    end
    @(negedge clk);
    fsync = 1'b0; reg_we = 1'b0;
    if (mid) m_ten[7:0] = m_ten[7:0] ^ 8'h08;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL R3 watchdog expired act=%0d exp=%0d", n_chk, 0);
    finish_run();
  end

  initial begin
    m_ten = '0; m_ren = '1; m_tsel = '0; m_rsel = '0; m_idle = 8'hFF;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(!hwa_tx_oe && !hwb_tx_oe && !rx_valid, "R1", "outputs after reset",
        {hwa_tx_oe, hwb_tx_oe, rx_valid}, 0);
    for (int a = 0; a < 17; a++)
      rd_chk(a, (a >= 4 && a < 8) ? 8'hFF : (a == 16 ? 8'hFF : 8'h00), "R1");

    // default frame: every outbound slot high impedance, inbound from A
    run_frame(1'b0);

    m_idle = 8'h5A;
    wr(16, m_idle);
    rd_chk(16, 8'h5A, "R2");

    // table of per-slot settings, one frame each
    for (int i = 0; i < 8; i++) begin
      int sl;
      sl = int'(VEC[i][8:4]);
      m_ten[sl]  = VEC[i][3];
      m_tsel[sl] = VEC[i][2];
      m_ren[sl]  = VEC[i][1];
      m_rsel[sl] = VEC[i][0];
      push_all();
      run_frame(1'b0);
    end

    // bit-to-slot mapping across all groups
    for (int k = 0; k < 4; k++) begin
      rd_chk(k,      m_ten[8*k +: 8],  "R2");
      rd_chk(4 + k,  m_ren[8*k +: 8],  "R2");
      rd_chk(8 + k,  m_tsel[8*k +: 8], "R2");
      rd_chk(12 + k, m_rsel[8*k +: 8], "R2");
    end

    // write to an unmapped address: reads zero, nothing else changes
    wr(20, 8'hAA);
    rd_chk(20, 8'h00, "R2");
    rd_chk(16, m_idle, "R2");
    rd_chk(0, m_ten[7:0], "R2");

    // slot 3 enabled by a write at its own bit 3; then in force next frame
    run_frame(1'b1);
    rd_chk(0, m_ten[7:0], "R8");
    run_frame(1'b0);

    // counter left out of step, then resynchronised by fsync
    repeat (5) @(negedge clk);
    run_frame(1'b0);

    finish_run();
  end
endmodule